// File: doc/BRIEF.md
# Dual-Vector Peripheral Interrupt Requester

This block is the flag and interrupt section of a bus peripheral that exchanges commands with a host through small control and status registers. It answers the host on two separate interrupt vectors. The host asks for the device's command registers by setting a request-input control bit. The device then raises a ready-input flag and asks for interrupt A. When the device has a finished result to hand back, it raises a ready-output flag and asks for interrupt B.

The host takes ready-input away by writing a command. Ready-input comes back on the next cycle if the host is still requesting and the device is not busy. That return produces another A interrupt right away, so a queue of commands drains one interrupt at a time. A request is withdrawn as soon as its ready flag falls.

On a bus grant the block presents the winning vector for one cycle. Vector A is the base address and vector B is the base plus 4, and A wins when both are pending. The granted source then stays quiet until its ready flag is set again. Clearing the run bit drops both flags and both requests.

Top module: `dual_vec_irq`

## Requirements
- R1: After reset the status byte is zero, `irq` is low and `vec_vld` is low.
- R2: Control byte fields are: bit 0 run, bit 1 input-interrupt enable, bit 2 output-interrupt enable, bit 3 request-input. A write takes effect on the next edge. One edge later, ready-input (status bit 4) is set if run and request-input are both set and `dev_busy` is low.
- R3: A `cmd_wr` pulse clears ready-input on the next edge. Ready-input is set again on the following edge only if request-input is still set and `dev_busy` is low. It stays clear while `dev_busy` is high or request-input is clear.
- R4: With run set, a `dev_done` pulse sets ready-output (status bit 7) on the next edge. An `out_taken` pulse clears it. When both arrive in the same cycle, ready-output is set.
- R5: `irq` rises one edge after a ready flag is set, provided that flag's enable bit is set and its source has not been serviced. The two enables gate their sources independently.
- R6: When a ready flag is cleared, `irq` falls one edge later unless the other source still requests.
- R7: A `bus_grant` sampled while a request is pending drives `vec_vld` high for one cycle. `vec_out` is VEC_BASE for source A (ready-input) and VEC_BASE+4 for source B (ready-output).
- R8: When both sources are pending at the grant, source A is granted, and source B is granted on a later grant.
- R9: A granted source raises no further request until its ready flag has been cleared and set again.
- R10: Clearing run clears both ready flags one edge after the control write takes effect, and `irq` is low one edge later. `dev_done` has no effect while run is clear.
- R11: A `bus_grant` with nothing pending leaves `vec_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 4 | Control bits: run, input enable, output enable, request-input |
| cmd_wr | input | 1 | Host wrote a command (clears ready-input) |
| dev_busy | input | 1 | Device cannot accept a new command yet |
| dev_done | input | 1 | Device has a completion to report |
| out_taken | input | 1 | Host consumed the completion (clears ready-output) |
| bus_grant | input | 1 | Interrupt grant from the bus |
| stat_byte | output | 8 | Status byte: bit 4 ready-input, bit 7 ready-output |
| irq | output | 1 | Interrupt request to the bus |
| vec_vld | output | 1 | Vector valid, one cycle per grant |
| vec_out | output | VEC_W | Granted vector address |

## Verification
Two functions of this block can fall in the same cycle. A bus grant can be answered in the cycle where the host's command write withdraws ready-input. The bench provokes this by pulsing `bus_grant` and `cmd_wr` together. It expects vector A to be delivered from the state seen at that edge, ready-input to read clear, and the serviced mark to be dropped. Because request-input is still set, ready-input and a fresh A request must then return on the next two edges. A second overlap, `dev_done` arriving with `out_taken`, is judged by ready-output remaining set.

// File: rtl/dvi_pkg.sv
package dvi_pkg;
  // control bit positions
  localparam int CTL_BITS    = 4;
  localparam int CTL_RUN     = 0;
  localparam int CTL_IEN_IN  = 1;
  localparam int CTL_IEN_OUT = 2;
  localparam int CTL_REQ_IN  = 3;
  // status bit positions decoded by the host driver
  localparam int STAT_W       = 8;
  localparam int STAT_RDY_IN  = 4;
  localparam int STAT_RDY_OUT = 7;
  // source indices; lower index has higher priority
  localparam int NSRC  = 2;
  localparam int SRC_A = 0;
  localparam int SRC_B = 1;
  localparam int VEC_STEP = 4;
endpackage

// File: rtl/dvi_csr_flags.sv
module dvi_csr_flags
  import dvi_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ctl_we,
  input  logic [CTL_BITS-1:0] ctl_wdata,
  input  logic                cmd_wr,
  input  logic                dev_busy,
  input  logic                dev_done,
  input  logic                out_taken,
  output logic [CTL_BITS-1:0] ctl_q,
  output logic                rdy_in_q,
  output logic                rdy_out_q
);
  logic run;
  logic rdy_in_d, rdy_out_d;

  assign run = ctl_q[CTL_RUN];

  always_comb begin
    rdy_in_d = rdy_in_q;
    if (!run)
      rdy_in_d = 1'b0;
    else if (cmd_wr)
      rdy_in_d = 1'b0;
    else if (ctl_q[CTL_REQ_IN] && !dev_busy)
      rdy_in_d = 1'b1;
  end

  always_comb begin
    rdy_out_d = rdy_out_q;
    if (!run)
      rdy_out_d = 1'b0;
    else if (dev_done)
      rdy_out_d = 1'b1;
    else if (out_taken)
      rdy_out_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      rdy_in_q  <= 1'b0;
      rdy_out_q <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      rdy_in_q  <= rdy_in_d;
      rdy_out_q <= rdy_out_d;
    end
  end
endmodule

// File: rtl/dvi_vec_arb.sv
module dvi_vec_arb
  import dvi_pkg::*;
#(
  parameter int              VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'd192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  rdy,
  input  logic [NSRC-1:0]  ien,
  input  logic             bus_grant,
  output logic [NSRC-1:0]  pend,
  output logic             irq,
  output logic             vec_vld,
  output logic [VEC_W-1:0] vec_out
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  serv_q, serv_d, gnt;
  logic [IDX_W-1:0] idx;
  logic             found;

  assign pend = rdy & ien & ~serv_q;

  // fixed priority: lowest index wins
  always_comb begin
    gnt   = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (!found && pend[i] && bus_grant) begin
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  // a source stays serviced only while its ready flag holds
  assign serv_d = rdy & (serv_q | gnt);

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_serv
      always_ff @(posedge clk) begin
        if (rst) serv_q[g] <= 1'b0;
        else     serv_q[g] <= serv_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      vec_vld <= 1'b0;
      vec_out <= '0;
    end else begin
      irq     <= |(rdy & ien & ~serv_d);
      vec_vld <= found;
      if (found)
        vec_out <= VEC_BASE + (VEC_W'(idx) * VEC_W'(VEC_STEP));
    end
  end
endmodule

// File: rtl/dual_vec_irq.sv
module dual_vec_irq
  import dvi_pkg::*;
#(
  parameter int               VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'd192
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [3:0]       ctl_wdata,
  input  logic             cmd_wr,
  input  logic             dev_busy,
  input  logic             dev_done,
  input  logic             out_taken,
  input  logic             bus_grant,
  output logic [7:0]       stat_byte,
  output logic             irq,
  output logic             vec_vld,
  output logic [VEC_W-1:0] vec_out
);
  logic [CTL_BITS-1:0] ctl_q;
  logic                rdy_in_q, rdy_out_q;
  logic [NSRC-1:0]     rdy, ien, pend;

  dvi_csr_flags u_flags (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmd_wr(cmd_wr), .dev_busy(dev_busy), .dev_done(dev_done),
    .out_taken(out_taken), .ctl_q(ctl_q),
    .rdy_in_q(rdy_in_q), .rdy_out_q(rdy_out_q)
  );

  assign rdy[SRC_A] = rdy_in_q;
  assign rdy[SRC_B] = rdy_out_q;
  assign ien[SRC_A] = ctl_q[CTL_IEN_IN];
  assign ien[SRC_B] = ctl_q[CTL_IEN_OUT];

  dvi_vec_arb #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_arb (
    .clk(clk), .rst(rst), .rdy(rdy), .ien(ien), .bus_grant(bus_grant),
    .pend(pend), .irq(irq), .vec_vld(vec_vld), .vec_out(vec_out)
  );

  always_comb begin
    stat_byte               = '0;
    stat_byte[STAT_RDY_IN]  = rdy_in_q;
    stat_byte[STAT_RDY_OUT] = rdy_out_q;
  end
endmodule

// File: rtl/dual_vec_irq_chk.sv
module dual_vec_irq_chk #(
  parameter int               VEC_W    = 9,
  parameter logic [VEC_W-1:0] VEC_BASE = 9'd192
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       ctl_q,
  input logic             rdy_in_q,
  input logic             rdy_out_q,
  input logic [1:0]       pend,
  input logic             bus_grant,
  input logic             irq,
  input logic             vec_vld,
  input logic [VEC_W-1:0] vec_out
);
  localparam logic [VEC_W-1:0] VEC_B = VEC_BASE + VEC_W'(4);

  // R7
  vec_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    vec_vld |-> $past(bus_grant));

  // R7
  vec_a_source_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_vld && vec_out == VEC_BASE) |-> $past(pend[0]));

  // R8
  b_yields_to_a_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_vld && vec_out == VEC_B) |-> ($past(pend[1]) && !$past(pend[0])));

  // R10
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[0] |=> (!rdy_in_q && !rdy_out_q));

  // R6
  irq_withdraw_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((rdy_in_q && ctl_q[1]) || (rdy_out_q && ctl_q[2])));

  // R2
  rdy_in_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_in_q) |-> $past(ctl_q[3] && ctl_q[0]));
endmodule

bind dual_vec_irq dual_vec_irq_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .ctl_q(ctl_q), .rdy_in_q(rdy_in_q),
  .rdy_out_q(rdy_out_q), .pend(pend), .bus_grant(bus_grant), .irq(irq),
  .vec_vld(vec_vld), .vec_out(vec_out)
);

// File: tb/sim_dual_vec_irq.sv
module sim_dual_vec_irq;
  localparam int CLK_P = 10;
  localparam int VW = 9;
  localparam logic [VW-1:0] VB = 9'd192;
  localparam int RUN = 1, IEN_A = 2, IEN_B = 4, REQ = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_we = 0, cmd_wr = 0, dev_busy = 0, dev_done = 0, out_taken = 0, bus_grant = 0;
  logic [3:0] ctl_wdata = '0;
  logic [7:0] stat_byte;
  logic irq, vec_vld;
  logic [VW-1:0] vec_out;
  int checks = 0, errors = 0;

  dual_vec_irq #(.VEC_W(VW), .VEC_BASE(VB)) u0 (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmd_wr(cmd_wr), .dev_busy(dev_busy), .dev_done(dev_done),
    .out_taken(out_taken), .bus_grant(bus_grant), .stat_byte(stat_byte),
    .irq(irq), .vec_vld(vec_vld), .vec_out(vec_out)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; step(2); rst = 1'b0;
  endtask

  task automatic wr_ctl(input int v);
    ctl_we = 1'b1; ctl_wdata = 4'(v); step(1); ctl_we = 1'b0;
  endtask

  task automatic p_done();  dev_done = 1;  step(1); dev_done = 0;  endtask
  task automatic p_taken(); out_taken = 1; step(1); out_taken = 0; endtask
  task automatic p_cmd();   cmd_wr = 1;    step(1); cmd_wr = 0;    endtask
  task automatic p_grant(); bus_grant = 1; step(1); bus_grant = 0; endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 stat", stat_byte, 0);
    chk("R1 irq", irq, 0);
    chk("R1 vec_vld", vec_vld, 0);

    // sweep enables x ready sources
    for (int en = 0; en < 4; en++) begin
      for (int src = 0; src < 4; src++) begin
        int ea, eb, exp_irq;
        do_reset();
        wr_ctl(RUN | (en << 1) | ((src & 1) ? REQ : 0));
        if (src & 2) p_done(); else step(1);
        step(1);
        ea = ((src & 1) && (en & 1)) ? 1 : 0;
        eb = ((src & 2) && (en & 2)) ? 1 : 0;
        exp_irq = ea | eb;
        chk("R2 rdy_in", stat_byte[4], src & 1);
        chk("R4 rdy_out", stat_byte[7], (src >> 1) & 1);
        chk("R5 irq", irq, exp_irq);
        p_grant();
        chk("R7/R11 vec_vld", vec_vld, exp_irq);
        if (exp_irq != 0)
          chk("R8 vec", vec_out, ea ? VB : VB + 4);
        chk("R9 irq after grant", irq, ea & eb);
        if (ea & eb) begin
          p_grant();
          chk("R8 second vec_vld", vec_vld, 1);
          chk("R8 second vec", vec_out, VB + 4);
          chk("R9 irq quiet", irq, 0);
        end
      end
    end

    // R3: busy holds ready-input clear, then immediate new A request
    do_reset();
    wr_ctl(RUN | IEN_A | REQ); step(2);
    p_grant();
    dev_busy = 1; p_cmd();
    chk("R3 rdy_in cleared", stat_byte[4], 0);
    step(2);
    chk("R3 busy holds", stat_byte[4], 0);
    chk("R3 busy irq", irq, 0);
    dev_busy = 0; step(1);
    chk("R3 rdy_in back", stat_byte[4], 1);
    step(1);
    chk("R3 new A irq", irq, 1);

    // R3: request-input cleared -> no further A
    wr_ctl(RUN | IEN_A); p_cmd(); step(3);
    chk("R3 no req rdy_in", stat_byte[4], 0);
    chk("R3 no req irq", irq, 0);

    // R4: done and taken same cycle -> set
    do_reset();
    wr_ctl(RUN | IEN_B); p_done(); step(1);
    dev_done = 1; out_taken = 1; step(1); dev_done = 0; out_taken = 0;
    chk("R4 done wins", stat_byte[7], 1);
    p_taken();
    chk("R4 taken clears", stat_byte[7], 0);
    chk("R6 irq lags", irq, 1);
    step(1);
    chk("R6 irq withdrawn", irq, 0);

    // R10: run clear drops both; dev_done ignored
    do_reset();
    wr_ctl(RUN | IEN_A | IEN_B | REQ); p_done(); step(1);
    chk("R10 pre irq", irq, 1);
    wr_ctl(0); step(1);
    chk("R10 flags clear", stat_byte, 0);
    step(1);
    chk("R10 irq low", irq, 0);
    p_done(); step(1);
    chk("R10 done ignored", stat_byte[7], 0);
    chk("R10 irq stays low", irq, 0);

    // R11: grant with nothing pending
    p_grant();
    chk("R11 no vec", vec_vld, 0);

    // overlap: grant with command write
    do_reset();
    wr_ctl(RUN | IEN_A | REQ); step(2);
    bus_grant = 1; cmd_wr = 1; step(1); bus_grant = 0; cmd_wr = 0;
    chk("R7 overlap vec_vld", vec_vld, 1);
    chk("R7 overlap vec", vec_out, VB);
    chk("R3 overlap rdy_in", stat_byte[4], 0);
    step(1);
    chk("R3 overlap rdy back", stat_byte[4], 1);
    chk("R9 overlap irq low", irq, 0);
    step(1);
    chk("R9 overlap new A", irq, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule